// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog counter for a peripheral clock domain. An 8-bit up-counter advances on ticks taken from a 12-bit prescaler. A 3-bit select field picks one of eight division ratios, and these ratios are not evenly spaced. Software starts and stops the timer through a run bit. When the counter wraps, the block raises a sticky flag and a one-cycle pulse.

Writes are guarded against runaway code. A write to either register must be a 16-bit access, and its upper byte must carry that register's own key. Only then is the lower byte stored. Any other write is dropped without notice. Reads have no such restriction.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0x00 and the control byte reads 0x00, which means select 000, stopped and flag clear. The overflow pulse and the flag outputs are low.
- R2: Only a write with `bus_size` = 01 (16-bit) can change either register. Writes with size 00 (8-bit) or 10 (32-bit) leave both registers unchanged.
- R3: A 16-bit write to address 0 whose data has upper byte 0x5A loads the lower byte into the counter. Any other upper byte, 0xA5 included, is ignored.
- R4: A 16-bit write to address 1 whose data has upper byte 0xA5 writes the control byte. Any other upper byte, 0x5A included, is ignored. In the control byte, bit 7 is the overflow flag, bit 6 is run, bits 2:0 are select, and bits 5:3 read 0.
- R5: The select encodings 000..111 divide the clock by 1, 4, 16, 32, 64, 256, 1024 and 4096. Call the ratio N. The first increment lands N cycles after the write edge that sets run, and further increments follow every N cycles. While the timer is stopped, the prescaler is held at zero, so each restart begins a full period.
- R6: A control write has no effect on the select field if the timer was running at that clock edge. The run bit and the flag bit of that write still apply.
- R7: When the counter advances from 0xFF to 0x00, `ovf_pulse` is high for exactly the one cycle in which the counter reads 0x00. In the same cycle the flag (bit 7, `ovf_flag`) becomes set.
- R8: A keyed control write with bit 7 = 0 clears the flag. Writing bit 7 = 1 leaves the flag as it was.
- R9: `bus_rdata` follows `bus_addr` combinationally. Address 0 gives the counter and address 1 gives the control byte, each in bits 7:0, with bits 15:8 equal to zero.
- R10: A keyed counter write while the timer runs takes priority over an increment at the same edge. Counting then continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 counter, 1 control |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_rdata | output | 16 | Read data of the addressed register |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume several things about the inputs. `bus_size` only ever holds 00, 01 or 10. Each write strobe stands for one access, and the bus inputs are known from reset onward. The bench meets these assumptions by driving the bus only on falling edges, lowering the strobe after a single rising edge, and using only those three size codes. Its counting windows are counted from the rising edge that takes the write.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int         PRE_W   = 12,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CSR_KEY = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_addr,
  input  logic        bus_we,
  input  logic [1:0]  bus_size,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        ovf_pulse,
  output logic        ovf_flag
);

  localparam logic [1:0] SZ_WORD = 2'b01;

  logic [7:0]       cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [2:0]       sel_q;
  logic             run_q;
  logic             flag_q;
  logic             pulse_q;

  function automatic logic [PRE_W-1:0] tap_mask(input logic [2:0] s);
    int sh;
    logic [PRE_W:0] one;
    case (s)
      3'd0: sh = 0;
      3'd1: sh = 2;
      3'd2: sh = 4;
      3'd3: sh = 5;
      3'd4: sh = 6;
      3'd5: sh = 8;
      3'd6: sh = 10;
      default: sh = 12;
    endcase
    one = 1;
    return PRE_W'((one << sh) - 1'b1);
  endfunction

  wire word_wr = bus_we && (bus_size == SZ_WORD);
  wire cnt_wr  = word_wr && !bus_addr && (bus_wdata[15:8] == CNT_KEY);
  wire csr_wr  = word_wr &&  bus_addr && (bus_wdata[15:8] == CSR_KEY);

  wire [PRE_W-1:0] mask = tap_mask(sel_q);
  wire tick = run_q && ((pre_q & mask) == mask);
  wire wrap = tick && (cnt_q == 8'hFF) && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      sel_q   <= '0;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pre_q   <= run_q ? pre_q + 1'b1 : '0;
      pulse_q <= wrap;
      if (cnt_wr)    cnt_q <= bus_wdata[7:0];
      else if (tick) cnt_q <= cnt_q + 8'd1;
      if (wrap)                        flag_q <= 1'b1;
      else if (csr_wr && !bus_wdata[7]) flag_q <= 1'b0;
      if (csr_wr)           run_q <= bus_wdata[6];
      if (csr_wr && !run_q) sel_q <= bus_wdata[2:0];
    end
  end

  assign bus_rdata = bus_addr ? {8'h00, flag_q, run_q, 3'b000, sel_q}
                              : {8'h00, cnt_q};
  assign ovf_pulse = pulse_q;
  assign ovf_flag  = flag_q;

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_addr,
  input logic       bus_we,
  input logic [1:0] bus_size,
  input logic       ovf_pulse,
  input logic       ovf_flag,
  input logic [7:0] cnt_q,
  input logic [2:0] sel_q,
  input logic       run_q
);

  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_flag && cnt_q == 8'h00);

  a_r6_sel_held_running: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> $stable(sel_q));

  a_r2_odd_size_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && bus_we && bus_size != 2'b01) |=>
      $stable(cnt_q) && $stable(sel_q) && !run_q);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(bus_we && !bus_addr)) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1));

endmodule

bind keyed_wdt keyed_wdt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_size(bus_size), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag),
  .cnt_q(cnt_q), .sel_q(sel_q), .run_q(run_q)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_addr = 0;
  logic        bus_we = 0;
  logic [1:0]  bus_size = 2'b01;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ovf_pulse, ovf_flag;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  keyed_wdt dut_i (.*);

  // {size, addr, wdata, expected counter, expected control}
  localparam logic [34:0] VEC [0:10] = '{
    {2'd1, 1'b0, 16'h5A37, 8'h37, 8'h00},
    {2'd0, 1'b0, 16'h5A11, 8'h37, 8'h00},
    {2'd2, 1'b0, 16'h5A22, 8'h37, 8'h00},
    {2'd1, 1'b0, 16'h5B44, 8'h37, 8'h00},
    {2'd1, 1'b0, 16'hA555, 8'h37, 8'h00},
    {2'd1, 1'b1, 16'hA503, 8'h37, 8'h03},
    {2'd1, 1'b1, 16'h5A05, 8'h37, 8'h03},
    {2'd0, 1'b1, 16'hA507, 8'h37, 8'h03},
    {2'd1, 1'b1, 16'hA507, 8'h37, 8'h07},
    {2'd1, 1'b1, 16'hA587, 8'h37, 8'h07},
    {2'd1, 1'b1, 16'hA500, 8'h37, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_size = sz; bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_cnt(input string req, input logic [7:0] exp);
    logic [15:0] d;
    rd(1'b0, d);
    chk(req, d, {8'h00, exp});
  endtask

  task automatic chk_csr(input string req, input logic [7:0] exp);
    logic [15:0] d;
    rd(1'b1, d);
    chk(req, d, {8'h00, exp});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk_cnt("R1 counter", 8'h00);
    chk_csr("R1 control", 8'h00);
    chk("R1 pulse", {15'h0, ovf_pulse}, 16'h0);
    chk("R1 flag", {15'h0, ovf_flag}, 16'h0);

    // R2 R3 R4 R9 vector walk (timer stopped)
    for (int i = 0; i < 11; i++) begin
      logic [34:0] v;
      string req;
      v = VEC[i];
      req = (v[34:33] != 2'd1) ? "R2" : (v[32] ? "R4" : "R3");
      wr(v[34:33], v[32], v[31:16]);
      chk_cnt({req, " R9 counter"}, v[15:8]);
      chk_csr({req, " R9 control"}, v[7:0]);
    end

    // R5 divide by 4
    wr(2'd1, 1'b0, 16'h5A00);
    wr(2'd1, 1'b1, 16'hA541);
    step(3);  chk_cnt("R5 div4 before", 8'h00);
    step(1);  chk_cnt("R5 div4 first", 8'h01);
    step(4);  chk_cnt("R5 div4 second", 8'h02);

    // R6 select held while running, allowed while stopped
    wr(2'd1, 1'b1, 16'hA546);  chk_csr("R6 running", 8'h41);
    wr(2'd1, 1'b1, 16'hA500);  chk_csr("R6 stop edge", 8'h01);
    wr(2'd1, 1'b1, 16'hA506);  chk_csr("R6 stopped", 8'h06);
    wr(2'd1, 1'b1, 16'hA500);

    // R5 prescaler cleared while stopped (div 64)
    wr(2'd1, 1'b0, 16'h5A00);
    wr(2'd1, 1'b1, 16'hA544);
    step(30);
    wr(2'd1, 1'b1, 16'hA504);  chk_csr("R5 stopped", 8'h04);
    chk_cnt("R5 partial period", 8'h00);
    wr(2'd1, 1'b1, 16'hA544);
    step(63); chk_cnt("R5 restart before", 8'h00);
    step(1);  chk_cnt("R5 restart first", 8'h01);

    // R5 divide by 4096
    wr(2'd1, 1'b1, 16'hA504);
    wr(2'd1, 1'b0, 16'h5A00);
    wr(2'd1, 1'b1, 16'hA547);
    step(4095); chk_cnt("R5 div4096 before", 8'h00);
    step(1);    chk_cnt("R5 div4096 first", 8'h01);

    // R7 overflow at divide by 1
    wr(2'd1, 1'b1, 16'hA500);
    wr(2'd1, 1'b0, 16'h5AFD);
    wr(2'd1, 1'b1, 16'hA540);
    step(2);
    chk_cnt("R7 at FF", 8'hFF);
    chk("R7 no pulse yet", {15'h0, ovf_pulse}, 16'h0);
    chk_csr("R7 no flag yet", 8'h40);
    step(1);
    chk_cnt("R7 wrapped", 8'h00);
    chk("R7 pulse", {15'h0, ovf_pulse}, 16'h1);
    chk_csr("R7 flag", 8'hC0);
    step(1);
    chk("R7 pulse ends", {15'h0, ovf_pulse}, 16'h0);
    chk_cnt("R7 continues", 8'h01);

    // R8 flag clearing
    wr(2'd1, 1'b1, 16'hA5C0);  chk_csr("R8 write one keeps", 8'hC0);
    wr(2'd1, 1'b1, 16'hA540);  chk_csr("R8 cleared", 8'h40);
    chk("R8 flag port", {15'h0, ovf_flag}, 16'h0);

    // R10 counter write while running
    wr(2'd1, 1'b0, 16'h5A10);  chk_cnt("R10 loaded", 8'h10);
    step(1);                   chk_cnt("R10 continues", 8'h11);
    wr(2'd1, 1'b0, 16'h5AFF);  chk_cnt("R10 load FF", 8'hFF);
    step(1);
    chk("R10 R7 wrap pulse", {15'h0, ovf_pulse}, 16'h1);
    chk_csr("R10 R7 flag", 8'hC0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule